// File: doc/BRIEF.md
# Internal Reset Sequencer with Timed Release

This block merges several on-chip reset requests into one held internal reset and lets it go only after a timed interval picked by the source. Four sources are accepted: a wake strobe that ends deep standby, an event from the independent watchdog, an event from the main watchdog, and a software request made by writing a key word. A watchdog event counts only when that watchdog's reset-enable input is high. The watchdog events are a counter underflow and a refresh attempt while refresh is locked.

A wake from deep standby is released in two phases. The reset rises at once. After a return interval the block gives a one-cycle exit strobe and starts a second wait interval. The reset falls only when that wait ends. Watchdog and software requests hold the reset for a single fixed interval. A cause register shows which source made the most recent reset and keeps that value until software clears it bit by bit. The asynchronous active-low power-on input overrides everything.

The controller has four states. `ST_IDLE` means no reset is held. `ST_DS_RETURN` counts the return interval after a wake. `ST_DS_WAIT` counts the post-exit wait. `ST_HOLD` counts the fixed interval for watchdog and software resets. Transitions: any accepted event moves from any state to `ST_DS_RETURN` (wake source) or to `ST_HOLD` (other sources) and reloads the counter. `ST_DS_RETURN` moves to `ST_DS_WAIT` when its count expires. `ST_DS_WAIT` and `ST_HOLD` move to `ST_IDLE` when their counts expire. Power-on reset forces `ST_IDLE`.

Top module: `intrst_sequencer`

## Requirements
- R1: While `por_n` is low, `rst_hold` is 1, `stby_exit` is 0 and `cause` is 0. After `por_n` goes high with no event, `rst_hold` is 0 from the next clock onward. Pulling `por_n` low in mid-sequence aborts the sequence.
- R2: A `dsw_wake` strobe sampled at a clock edge makes `rst_hold` 1 after that edge and keeps it high for exactly T_DSBY + T_DSBYWT cycles.
- R3: During a wake sequence, `stby_exit` is high for exactly one cycle. That cycle is the (T_DSBY+1)-th cycle of the held reset, counting the first held cycle as the 1st.
- R4: An independent-watchdog underflow or locked-refresh strobe holds `rst_hold` for T_RESW2 cycles when `iw_rst_en` is 1. When `iw_rst_en` is 0 it has no effect on any output.
- R5: The main-watchdog strobes behave as in R4, gated by their own enable `mw_rst_en`.
- R6: A write with `reg_sel`=0 whose data equals 16'hA501 holds `rst_hold` for T_RESW2 cycles. A write of any other value with `reg_sel`=0 has no effect on any output.
- R7: An accepted event that arrives while a reset is held restarts the count for the new source. The remaining hold is then the new source's full interval, and a pending `stby_exit` is dropped.
- R8: When several sources fire in the same cycle, only one is taken. The order from highest to lowest is wake, independent watchdog, main watchdog, software.
- R9: `cause` is one-hot with bit 0 for wake, bit 1 for independent watchdog, bit 2 for main watchdog and bit 3 for software. It shows the last accepted source and keeps that value through and after the release.
- R10: A write with `reg_sel`=1 clears each `cause` bit whose position is 1 in `reg_wdata[3:0]`. If an event is accepted in the same cycle, the event's value wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| por_n | input | 1 | Asynchronous active-low power-on reset |
| dsw_wake | input | 1 | Deep-standby cancel strobe |
| iw_underflow | input | 1 | Independent watchdog underflow strobe |
| iw_badref | input | 1 | Independent watchdog refresh-while-locked strobe |
| iw_rst_en | input | 1 | Independent watchdog reset-output enable |
| mw_underflow | input | 1 | Main watchdog underflow strobe |
| mw_badref | input | 1 | Main watchdog refresh-while-locked strobe |
| mw_rst_en | input | 1 | Main watchdog reset-output enable |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 = software key register, 1 = cause clear |
| reg_wdata | input | 16 | Register write data |
| rst_hold | output | 1 | Held internal reset, active high |
| stby_exit | output | 1 | One-cycle deep-standby exit strobe |
| cause | output | 4 | Reset cause, one-hot |

## Verification
The assertions assume that the event strobes and register writes are synchronous to `clk` and that `por_n` is the only asynchronous input. They also assume that every interval parameter is at least 1. The bench drives every input at the falling edge and holds a strobe for exactly one rising edge. It instantiates the block with short intervals, so every state and every restart point can be swept in full. It releases `por_n` at a falling edge, away from the sampling edge.

// File: rtl/intrst_pkg.sv
package intrst_pkg;

    localparam int NUM_SRC = 4;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_DS_RETURN = 2'd1,
        ST_DS_WAIT   = 2'd2,
        ST_HOLD      = 2'd3
    } seq_state_e;

    // index doubles as priority (lower wins) and as cause bit position
    typedef enum logic [1:0] {
        SRC_DSTBY = 2'd0,
        SRC_IWDT  = 2'd1,
        SRC_MWDT  = 2'd2,
        SRC_SOFT  = 2'd3
    } rst_src_e;

endpackage

// File: rtl/intrst_src_merge.sv
module intrst_src_merge
    import intrst_pkg::*;
#(
    parameter int          KEY_W  = 16,
    parameter logic [KEY_W-1:0] SW_KEY = 16'hA501
) (
    input  logic             dsw_wake,
    input  logic             iw_underflow,
    input  logic             iw_badref,
    input  logic             iw_rst_en,
    input  logic             mw_underflow,
    input  logic             mw_badref,
    input  logic             mw_rst_en,
    input  logic             key_wr,
    input  logic [KEY_W-1:0] key_data,
    output logic             ev_valid,
    output rst_src_e         ev_src
);

    logic [NUM_SRC-1:0] req;

    always_comb begin
        req                = '0;
        req[int'(SRC_DSTBY)] = dsw_wake;
        req[int'(SRC_IWDT)]  = iw_rst_en & (iw_underflow | iw_badref);
        req[int'(SRC_MWDT)]  = mw_rst_en & (mw_underflow | mw_badref);
        req[int'(SRC_SOFT)]  = key_wr && (key_data == SW_KEY);
    end

    // scan downward so the lowest active index is the last one written
    always_comb begin
        ev_src = SRC_SOFT;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (req[i]) ev_src = rst_src_e'(i);
        end
    end

    assign ev_valid = |req;

endmodule

// File: rtl/intrst_timer.sv
module intrst_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          por_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          done
);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)            cnt_q <= '0;
        else if (load)         cnt_q <= load_val;
        else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    assign done = (cnt_q == '0);

endmodule

// File: rtl/intrst_sequencer.sv
module intrst_sequencer
    import intrst_pkg::*;
#(
    parameter int T_DSBY   = 32,
    parameter int T_DSBYWT = 64,
    parameter int T_RESW2  = 16,
    parameter int KEY_W    = 16,
    parameter logic [KEY_W-1:0] SW_KEY = 16'hA501
) (
    input  logic               clk,
    input  logic               por_n,
    input  logic               dsw_wake,
    input  logic               iw_underflow,
    input  logic               iw_badref,
    input  logic               iw_rst_en,
    input  logic               mw_underflow,
    input  logic               mw_badref,
    input  logic               mw_rst_en,
    input  logic               reg_we,
    input  logic               reg_sel,
    input  logic [KEY_W-1:0]   reg_wdata,
    output logic               rst_hold,
    output logic               stby_exit,
    output logic [NUM_SRC-1:0] cause
);

    localparam int T_MAX_A = (T_DSBY > T_DSBYWT) ? T_DSBY : T_DSBYWT;
    localparam int T_MAX   = (T_MAX_A > T_RESW2) ? T_MAX_A : T_RESW2;
    localparam int CW      = $clog2(T_MAX) + 1;
    localparam logic [CW-1:0] LD_RETURN = CW'(T_DSBY - 1);
    localparam logic [CW-1:0] LD_WAIT   = CW'(T_DSBYWT - 1);
    localparam logic [CW-1:0] LD_HOLD   = CW'(T_RESW2 - 1);

    seq_state_e         state_q, state_d;
    logic               ev_valid;
    rst_src_e           ev_src;
    logic               tmr_load, tmr_done;
    logic [CW-1:0]      tmr_val;
    logic               exit_q;
    logic [NUM_SRC-1:0] cause_q;

    intrst_src_merge #(
        .KEY_W  (KEY_W),
        .SW_KEY (SW_KEY)
    ) u_merge (
        .dsw_wake     (dsw_wake),
        .iw_underflow (iw_underflow),
        .iw_badref    (iw_badref),
        .iw_rst_en    (iw_rst_en),
        .mw_underflow (mw_underflow),
        .mw_badref    (mw_badref),
        .mw_rst_en    (mw_rst_en),
        .key_wr       (reg_we && !reg_sel),
        .key_data     (reg_wdata),
        .ev_valid     (ev_valid),
        .ev_src       (ev_src)
    );

    intrst_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .por_n    (por_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    // next-state and counter load
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        if (ev_valid) begin
            tmr_load = 1'b1;
            if (ev_src == SRC_DSTBY) begin
                state_d = ST_DS_RETURN;
                tmr_val = LD_RETURN;
            end else begin
                state_d = ST_HOLD;
                tmr_val = LD_HOLD;
            end
        end else begin
            unique case (state_q)
                ST_IDLE: ;
                ST_DS_RETURN: if (tmr_done) begin
                    state_d  = ST_DS_WAIT;
                    tmr_load = 1'b1;
                    tmr_val  = LD_WAIT;
                end
                ST_DS_WAIT: if (tmr_done) state_d = ST_IDLE;
                ST_HOLD:    if (tmr_done) state_d = ST_IDLE;
            endcase
        end
    end

    // state register with exit strobe and cause record
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state_q <= ST_IDLE;
            exit_q  <= 1'b0;
            cause_q <= '0;
        end else begin
            state_q <= state_d;
            exit_q  <= (state_q == ST_DS_RETURN) && tmr_done && !ev_valid;
            if (ev_valid)
                cause_q <= NUM_SRC'(1) << ev_src;
            else if (reg_we && reg_sel)
                cause_q <= cause_q & ~reg_wdata[NUM_SRC-1:0];
        end
    end

    // outputs
    always_comb begin
        rst_hold  = !por_n || (state_q != ST_IDLE);
        stby_exit = exit_q;
        cause     = cause_q;
    end

    // R2 R4 R5 R6: any accepted event holds the reset on the next cycle
    a_r2_event_holds: assert property (@(posedge clk) disable iff (!por_n)
        ev_valid |=> rst_hold);

    // R3: exit strobe only appears in the post-exit wait, lasting one cycle
    a_r3_exit_in_wait: assert property (@(posedge clk) disable iff (!por_n)
        stby_exit |-> (state_q == ST_DS_WAIT) && rst_hold);
    a_r3_exit_single: assert property (@(posedge clk) disable iff (!por_n)
        stby_exit |=> !stby_exit);

    // R1: idle with no event stays released
    a_r1_idle_stays: assert property (@(posedge clk) disable iff (!por_n)
        (state_q == ST_IDLE && !ev_valid) |=> !rst_hold);

    // R9: cause is one-hot or empty
    a_r9_cause_onehot: assert property (@(posedge clk) disable iff (!por_n)
        $onehot0(cause));

    // R10: cleared bits are gone after a clear write without an event
    a_r10_clear_bits: assert property (@(posedge clk) disable iff (!por_n)
        (reg_we && reg_sel && !ev_valid) |=>
            ((cause & $past(reg_wdata[NUM_SRC-1:0])) == '0));

endmodule

// File: tb/sim_intrst_sequencer.sv
module sim_intrst_sequencer;

    localparam int CLK_PERIOD = 10;
    localparam int T1 = 3;
    localparam int T2 = 5;
    localparam int T3 = 2;
    localparam logic [15:0] KEY = 16'hA501;

    logic        clk = 1'b0;
    logic        por_n;
    logic        dsw_wake, iw_underflow, iw_badref, iw_rst_en;
    logic        mw_underflow, mw_badref, mw_rst_en;
    logic        reg_we, reg_sel;
    logic [15:0] reg_wdata;
    logic        rst_hold, stby_exit;
    logic [3:0]  cause;

    int n_vec  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    intrst_sequencer #(
        .T_DSBY(T1), .T_DSBYWT(T2), .T_RESW2(T3)
    ) u0 (
        .clk(clk), .por_n(por_n), .dsw_wake(dsw_wake),
        .iw_underflow(iw_underflow), .iw_badref(iw_badref), .iw_rst_en(iw_rst_en),
        .mw_underflow(mw_underflow), .mw_badref(mw_badref), .mw_rst_en(mw_rst_en),
        .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .rst_hold(rst_hold), .stby_exit(stby_exit), .cause(cause)
    );

    task automatic check(string req, int act, int exp);
        n_vec++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic drop_inputs();
        dsw_wake = 0; iw_underflow = 0; iw_badref = 0; iw_rst_en = 0;
        mw_underflow = 0; mw_badref = 0; mw_rst_en = 0;
        reg_we = 0; reg_sel = 0; reg_wdata = '0;
    endtask

    // apply one strobe pattern for exactly one rising edge
    task automatic fire(bit ds, bit iuf, bit ibr, bit ien, bit muf, bit mbr,
                        bit men, bit kw, logic [15:0] kd);
        @(negedge clk);
        dsw_wake = ds; iw_underflow = iuf; iw_badref = ibr; iw_rst_en = ien;
        mw_underflow = muf; mw_badref = mbr; mw_rst_en = men;
        reg_we = kw; reg_sel = 1'b0; reg_wdata = kd;
        @(posedge clk); #1;
        drop_inputs();
    endtask

    task automatic clear_cause(logic [3:0] m);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = 1'b1; reg_wdata = {12'h0, m};
        @(posedge clk); #1;
        drop_inputs();
    endtask

    task automatic measure(output int len, output int ex_at, output int ex_n);
        len = 0; ex_at = -1; ex_n = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (stby_exit) begin
                ex_n++;
                if (ex_at < 0) ex_at = i;
            end
            if (rst_hold) len++;
            else break;
        end
    endtask

    task automatic settle();
        repeat (T1 + T2 + 4) @(negedge clk);
    endtask

    // trigger source s alone
    task automatic trigger(int s);
        case (s)
            0: fire(1, 0, 0, 0, 0, 0, 0, 0, 16'h0);
            1: fire(0, 1, 0, 1, 0, 0, 0, 0, 16'h0);
            2: fire(0, 0, 0, 0, 1, 0, 1, 0, 16'h0);
            default: fire(0, 0, 0, 0, 0, 0, 0, 1, KEY);
        endcase
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        int len, ex_at, ex_n;
        drop_inputs();
        por_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 hold in por", int'(rst_hold), 1);
        check("R1 exit in por", int'(stby_exit), 0);
        check("R1 cause in por", int'(cause), 0);
        por_n = 1'b1;
        @(negedge clk);
        check("R1 released", int'(rst_hold), 0);

        // R2 R3 wake sequence
        trigger(0);
        measure(len, ex_at, ex_n);
        check("R2 wake hold length", len, T1 + T2);
        check("R3 exit position", ex_at, T1);
        check("R3 exit count", ex_n, 1);
        check("R9 wake cause", int'(cause), 1);
        settle();
        check("R9 cause kept after release", int'(cause), 1);
        clear_cause(4'hF);

        // R4 independent watchdog sweep
        for (int b = 0; b < 8; b++) begin
            bit en = b[2], uf = b[1], br = b[0];
            bit hit = en && (uf || br);
            fire(0, uf, br, en, 0, 0, 0, 0, 16'h0);
            measure(len, ex_at, ex_n);
            check("R4 iwdt hold length", len, hit ? T3 : 0);
            check("R4 iwdt cause", int'(cause), hit ? 2 : 0);
            settle();
            clear_cause(4'hF);
        end

        // R5 main watchdog sweep
        for (int b = 0; b < 8; b++) begin
            bit en = b[2], uf = b[1], br = b[0];
            bit hit = en && (uf || br);
            fire(0, 0, 0, 0, uf, br, en, 0, 16'h0);
            measure(len, ex_at, ex_n);
            check("R5 mwdt hold length", len, hit ? T3 : 0);
            check("R5 mwdt cause", int'(cause), hit ? 4 : 0);
            settle();
            clear_cause(4'hF);
        end

        // R6 key: exact value and every single-bit neighbour
        for (int k = 0; k <= 16; k++) begin
            logic [15:0] v = (k == 16) ? KEY : (KEY ^ (16'h1 << k));
            bit hit = (k == 16);
            fire(0, 0, 0, 0, 0, 0, 0, 1, v);
            measure(len, ex_at, ex_n);
            check("R6 key hold length", len, hit ? T3 : 0);
            check("R6 key cause", int'(cause), hit ? 8 : 0);
            settle();
            clear_cause(4'hF);
        end

        // R8 all simultaneous combinations
        for (int m = 1; m < 16; m++) begin
            int src = 0;
            for (int j = 3; j >= 0; j--) if (m[j]) src = j;
            fire(m[0], m[1], 0, 1, m[2], 0, 1, m[3], KEY);
            measure(len, ex_at, ex_n);
            check("R8 priority hold length", len, (src == 0) ? T1 + T2 : T3);
            check("R8 priority cause", int'(cause), 1 << src);
            settle();
            clear_cause(4'hF);
        end

        // R10 clear masks for every source
        for (int s = 0; s < 4; s++) begin
            for (int m = 0; m < 16; m++) begin
                trigger(s);
                settle();
                clear_cause(4'(m));
                @(negedge clk);
                check("R10 clear mask", int'(cause), (1 << s) & ~m & 15);
                clear_cause(4'hF);
            end
        end

        // R10 event in same cycle as clear wins
        @(negedge clk);
        iw_underflow = 1; iw_rst_en = 1;
        reg_we = 1; reg_sel = 1; reg_wdata = 16'h000F;
        @(posedge clk); #1;
        drop_inputs();
        @(negedge clk);
        check("R10 event beats clear", int'(cause), 2);
        settle();
        clear_cause(4'hF);

        // R7 restart from watchdog hold
        for (int k = 0; k < T3; k++) begin
            trigger(1);
            for (int j = 0; j < k; j++) begin
                @(negedge clk);
                check("R7 held before restart", int'(rst_hold), 1);
            end
            trigger(3);
            measure(len, ex_at, ex_n);
            check("R7 restart length", len, T3);
            check("R7 restart cause", int'(cause), 8);
            settle();
            clear_cause(4'hF);
        end

        // R7 restart from each point of a wake sequence
        for (int k = 0; k < T1 + T2 - 1; k++) begin
            trigger(0);
            for (int j = 0; j < k; j++) begin
                @(negedge clk);
                check("R7 held in wake", int'(rst_hold), 1);
            end
            trigger(2);
            measure(len, ex_at, ex_n);
            check("R7 wake restart length", len, T3);
            check("R7 no exit after restart", ex_n, 0);
            check("R7 wake restart cause", int'(cause), 4);
            settle();
            clear_cause(4'hF);
        end

        // R1 power-on in mid-sequence
        trigger(0);
        repeat (2) @(negedge clk);
        por_n = 1'b0;
        #1;
        check("R1 hold during por", int'(rst_hold), 1);
        check("R1 cause cleared by por", int'(cause), 0);
        @(negedge clk);
        por_n = 1'b1;
        repeat (T1 + 1) begin
            @(negedge clk);
            check("R1 aborted sequence", int'(rst_hold), 0);
            check("R1 no exit after abort", int'(stby_exit), 0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule